// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is a triangle-wave timer for center-aligned pulse-width modulation. A 16-bit counter climbs by one on each timer tick from zero to a programmable ceiling, holds that ceiling for a single tick, then falls back to zero and repeats. The ceiling comes either from a dedicated period register or from compare channel A, as selected by a mode input. Each compare channel drives one PWM pin, and its pin level is set or cleared when the counter equals the channel's active compare value.

Software writes new period and compare values into holding buffers with simple write strobes. Those values reach the active registers only on the tick when the counter sits at zero. Both slopes of every period therefore use the same numbers, and the waveform stays symmetric and frequency-correct while values change. Sticky event flags report the bottom of each period, the ceiling of each period when the period register sets it, and every compare match. Software clears a flag by writing a one to it.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: On each cycle with `tick` high, `count` moves by exactly one: upward from 0 to the ceiling, then downward back to 0. With `tick` low, `count` holds its value. After 0 the count always rises.
- R2: On the tick when `count` equals the ceiling while rising, and `count` is not 0, the direction turns. The next value is ceiling minus one, so the ceiling is held for exactly one tick. When the ceiling comes from the period register, `flag_top` sets on that tick.
- R3: With `top_sel` = 0 the ceiling is the active period value. With `top_sel` = 1 it is the active compare value of channel 0 (channel A).
- R4: Writes through `per_wr` and `cmp_wr[i]` go to holding buffers. A buffer is copied to its active register only on a tick taken with `count` = 0. A write part way through a period leaves the peak of that period unchanged.
- R5: `flag_bot` sets on every tick taken with `count` = 0, which is the same tick that copies the buffers.
- R6: `flag_cmp[i]` sets on every tick when `count` equals channel i's active compare value, in every output mode.
- R7: Channel mode is `cmp_mode[2i+1:2i]`. In mode 2 (normal), a match while rising drives the pin low and a match while falling drives it high. Mode 3 (inverted) does the reverse. The pin changes only one cycle after a tick.
- R8: In modes 0 and 1 the pin output is low. Compare flags still set on matches.
- R9: A channel whose active compare value is above the ceiling never matches. Its flag stays clear and its pin keeps its level.
- R10: Flags are sticky. A one on the matching clear input clears the flag on the next edge. When a set event and a clear happen in the same cycle, the set wins.
- R11: Reset (`rst_n` low, released two clocks after it rises) gives `count` = 0, direction up, all buffers, active registers, pins and flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Timer clock enable; the counter advances when high |
| top_sel | input | 1 | Ceiling source: 0 period register, 1 channel 0 compare |
| per_wr | input | 1 | Write strobe for the period buffer |
| per_wdata | input | 16 | Period value to write |
| cmp_wr | input | 3 | Per-channel write strobes for the compare buffers |
| cmp_wdata | input | 16 | Compare value to write |
| cmp_mode | input | 6 | Two mode bits per channel |
| clr_bot | input | 1 | Write-one clear of `flag_bot` |
| clr_top | input | 1 | Write-one clear of `flag_top` |
| clr_cmp | input | 3 | Write-one clears of `flag_cmp` |
| count | output | 16 | Current counter value |
| pwm | output | 3 | PWM pins |
| flag_bot | output | 1 | Bottom-of-period flag |
| flag_top | output | 1 | Ceiling flag (period-register mode) |
| flag_cmp | output | 3 | Compare match flags |

## Verification
The count, direction, pins and all flags are registered. Each of them reflects a tick one clock edge later. A buffer write shows only after the next tick at zero, which can be up to a full period later. Leaving reset adds two clocks of synchronizer delay before the first tick counts. The bench drives inputs and samples outputs on the falling edge. Before each rising edge it advances its own reference state by one edge, so every comparison falls on the first half-cycle in which the result is due. Directed sections measure peaks across whole periods, so buffered values are judged only after the bottom tick that loads them.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  typedef enum logic [1:0] {
    OM_OFF0 = 2'd0,
    OM_OFF1 = 2'd1,
    OM_NORM = 2'd2,
    OM_INV  = 2'd3
  } out_mode_e;

  // Level of the pin after a compare match, given the slope direction.
  function automatic logic match_level(input out_mode_e m, input logic rising, input logic cur);
    case (m)
      OM_NORM: return ~rising;
      OM_INV:  return rising;
      default: return cur;
    endcase
  endfunction

  function automatic logic pin_driven(input out_mode_e m);
    return (m == OM_NORM) || (m == OM_INV);
  endfunction

endpackage

// File: rtl/pdt_flag.sv
module pdt_flag (
  input  logic clk,
  input  logic rst_sn,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic q_r;

  always_comb begin
    q_d = q_r;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) q_r <= 1'b0;
    else         q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             tick,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic             bottom,
  output logic             turn
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  assign bottom = (cnt_q == '0);
  assign turn   = up_q && !bottom && (cnt_q >= top);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (tick) begin
      if (bottom) begin
        cnt_d = cnt_q + ONE;
        up_d  = 1'b1;
      end else if (turn) begin
        cnt_d = cnt_q - ONE;
        up_d  = 1'b0;
      end else if (up_q) begin
        cnt_d = cnt_q + ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt = cnt_q;
  assign up  = up_q;
endmodule

// File: rtl/pdt_channel.sv
module pdt_channel
  import pdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic             up,
  input  logic [1:0]       mode,
  input  logic             clr,
  output logic [CNT_W-1:0] act,
  output logic             pin,
  output logic             flag
);
  logic [CNT_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             lvl_q, lvl_d;
  logic             match;
  out_mode_e        om;

  assign om    = out_mode_e'(mode);
  assign match = tick && (cnt == act_q);

  always_comb begin
    buf_d = wr   ? wdata : buf_q;
    act_d = load ? buf_q : act_q;
    lvl_d = lvl_q;
    if (match) lvl_d = match_level(om, up, lvl_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      buf_q <= '0;
      act_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
      lvl_q <= lvl_d;
    end
  end

  pdt_flag u_flag (
    .clk   (clk),
    .rst_sn(rst_sn),
    .set   (match),
    .clr   (clr),
    .q     (flag)
  );

  assign act = act_q;
  assign pin = pin_driven(om) ? lvl_q : 1'b0;
endmodule

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               top_sel,
  input  logic               per_wr,
  input  logic [CNT_W-1:0]   per_wdata,
  input  logic [NCH-1:0]     cmp_wr,
  input  logic [CNT_W-1:0]   cmp_wdata,
  input  logic [2*NCH-1:0]   cmp_mode,
  input  logic               clr_bot,
  input  logic               clr_top,
  input  logic [NCH-1:0]     clr_cmp,
  output logic [CNT_W-1:0]   count,
  output logic [NCH-1:0]     pwm,
  output logic               flag_bot,
  output logic               flag_top,
  output logic [NCH-1:0]     flag_cmp
);
  localparam int SYNC_N = 2;

  // reset synchronizer: asserts at once, releases after SYNC_N edges
  logic [SYNC_N-1:0] rs_q, rs_d;
  logic              rst_sn;

  assign rs_d = {rs_q[SYNC_N-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_sn = rs_q[SYNC_N-1];

  // period register, double buffered
  logic [CNT_W-1:0] per_buf_q, per_buf_d;
  logic [CNT_W-1:0] per_act_q, per_act_d;
  logic [CNT_W-1:0] ch_act [NCH];
  logic [CNT_W-1:0] top_val;
  logic             cnt_up, at_bottom, at_turn, load;

  assign load      = tick && at_bottom;
  assign top_val   = top_sel ? ch_act[0] : per_act_q;

  always_comb begin
    per_buf_d = per_wr ? per_wdata : per_buf_q;
    per_act_d = load   ? per_buf_q : per_act_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      per_buf_q <= '0;
      per_act_q <= '0;
    end else begin
      per_buf_q <= per_buf_d;
      per_act_q <= per_act_d;
    end
  end

  pdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_sn(rst_sn),
    .tick  (tick),
    .top   (top_val),
    .cnt   (count),
    .up    (cnt_up),
    .bottom(at_bottom),
    .turn  (at_turn)
  );

  pdt_flag u_fbot (
    .clk   (clk),
    .rst_sn(rst_sn),
    .set   (load),
    .clr   (clr_bot),
    .q     (flag_bot)
  );

  pdt_flag u_ftop (
    .clk   (clk),
    .rst_sn(rst_sn),
    .set   (tick && at_turn && !top_sel),
    .clr   (clr_top),
    .q     (flag_top)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pdt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk   (clk),
      .rst_sn(rst_sn),
      .tick  (tick),
      .wr    (cmp_wr[i]),
      .wdata (cmp_wdata),
      .load  (load),
      .cnt   (count),
      .up    (cnt_up),
      .mode  (cmp_mode[2*i +: 2]),
      .clr   (clr_cmp[i]),
      .act   (ch_act[i]),
      .pin   (pwm[i]),
      .flag  (flag_cmp[i])
    );
  end
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_val,
  input logic             up,
  input logic             flag_bot,
  input logic             clr_bot,
  input logic [2*NCH-1:0] mode,
  input logic [NCH-1:0]   pwm
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    tick |=> ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !tick |=> $stable(cnt));

  p_turn_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && up && (cnt != '0) && (cnt == top_val)) |=> (!up && (cnt == $past(cnt) - ONE)));

  p_bot_flag_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && (cnt == '0)) |=> flag_bot);

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (clr_bot && !(tick && (cnt == '0))) |=> !flag_bot);

  p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!$past(tick) && $stable(mode)) |-> $stable(pwm));

  for (genvar i = 0; i < NCH; i++) begin : g_off
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_sn)
      !mode[2*i+1] |-> !pwm[i]);
  end
endmodule

bind pwm_dual_slope_timer pdt_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .tick    (tick),
  .cnt     (count),
  .top_val (top_val),
  .up      (cnt_up),
  .flag_bot(flag_bot),
  .clr_bot (clr_bot),
  .mode    (cmp_mode),
  .pwm     (pwm)
);

// File: tb/tb_pwm_dual_slope_timer.sv
`timescale 1ns/1ps
module tb_pwm_dual_slope_timer;
  localparam int W = 16;
  localparam int N = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, tick, top_sel, per_wr, clr_bot, clr_top;
  logic [W-1:0]   per_wdata, cmp_wdata, count;
  logic [N-1:0]   cmp_wr, clr_cmp, pwm, flag_cmp;
  logic [2*N-1:0] cmp_mode;
  logic           flag_bot, flag_top;

  pwm_dual_slope_timer #(.CNT_W(W), .NCH(N)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_sel(top_sel),
    .per_wr(per_wr), .per_wdata(per_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cmp_mode(cmp_mode), .clr_bot(clr_bot), .clr_top(clr_top), .clr_cmp(clr_cmp),
    .count(count), .pwm(pwm), .flag_bot(flag_bot), .flag_top(flag_top), .flag_cmp(flag_cmp)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_cnt, m_pbuf, m_pact;
  logic [W-1:0] m_cbuf [N];
  logic [W-1:0] m_cact [N];
  logic         m_up, m_fb, m_ft;
  logic [N-1:0] m_pin, m_fc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_pbuf = '0; m_pact = '0; m_up = 1'b1;
    m_fb = 0; m_ft = 0; m_pin = '0; m_fc = '0;
    for (int i = 0; i < N; i++) begin m_cbuf[i] = '0; m_cact[i] = '0; end
  endtask

  function automatic logic [W-1:0] ceil_now();
    return top_sel ? m_cact[0] : m_pact;
  endfunction

  // one rising edge of the reference, from requirements R1..R10
  task automatic model_step();
    logic [W-1:0] topv, ncnt;
    logic nup, bot, rev;
    logic [N-1:0] setc;
    topv = ceil_now();
    bot = (m_cnt == 0);
    rev = m_up && !bot && (m_cnt >= topv);
    setc = '0;
    ncnt = m_cnt; nup = m_up;
    if (tick) begin
      for (int i = 0; i < N; i++) begin
        if (m_cnt == m_cact[i]) begin
          setc[i] = 1'b1;
          if (cmp_mode[2*i +: 2] == 2'd2) m_pin[i] = ~m_up;
          else if (cmp_mode[2*i +: 2] == 2'd3) m_pin[i] = m_up;
        end
      end
      if (bot) begin ncnt = m_cnt + 1; nup = 1'b1; end
      else if (rev) begin ncnt = m_cnt - 1; nup = 1'b0; end
      else ncnt = m_up ? m_cnt + 1 : m_cnt - 1;
    end
    m_fb = (m_fb & ~clr_bot) | (tick & bot);
    m_ft = (m_ft & ~clr_top) | (tick & rev & ~top_sel);
    m_fc = (m_fc & ~clr_cmp) | setc;
    if (tick && bot) begin
      m_pact = m_pbuf;
      for (int i = 0; i < N; i++) m_cact[i] = m_cbuf[i];
    end
    if (per_wr) m_pbuf = per_wdata;
    for (int i = 0; i < N; i++) if (cmp_wr[i]) m_cbuf[i] = cmp_wdata;
    m_cnt = ncnt; m_up = nup;
  endtask

  task automatic compare_all();
    chk("R1 count", count, m_cnt);
    chk("R5 flag_bot", flag_bot, m_fb);
    chk("R2 flag_top", flag_top, m_ft);
    for (int i = 0; i < N; i++) begin
      chk("R6 flag_cmp", flag_cmp[i], m_fc[i]);
      if (cmp_mode[2*i+1]) chk("R7 pin", pwm[i], m_pin[i]);
      else                 chk("R8 pin off", pwm[i], 1'b0);
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    per_wr = 0; cmp_wr = '0; clr_bot = 0; clr_top = 0; clr_cmp = '0;
  endtask

  // run until count returns to zero; report the peak seen
  task automatic run_peak(output int peak);
    int guard;
    peak = 0; guard = 0;
    do begin
      cyc();
      if (int'(count) > peak) peak = int'(count);
      guard++;
    end while (count != 0 && guard < 400);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pk, pk2;
    logic held;
    logic [W-1:0] prev;
    void'($urandom(32'd20240611));
    rst_n = 0; tick = 0; top_sel = 0; per_wr = 0; per_wdata = '0;
    cmp_wr = '0; cmp_wdata = '0; cmp_mode = '0;
    clr_bot = 0; clr_top = 0; clr_cmp = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_reset();
    // R11 reset state
    chk("R11 count", count, 0);
    chk("R11 flags", {flag_bot, flag_top, flag_cmp}, 0);
    chk("R11 pins", pwm, 0);

    // R3: period register as ceiling
    tick = 1; top_sel = 0; per_wr = 1; per_wdata = 16'd6;
    cmp_mode = {2'd2, 2'd3, 2'd2};
    cyc();
    run_peak(pk); run_peak(pk);
    chk("R3 period ceiling", pk, 6);
    // R3: channel A as ceiling
    cmp_wr = 3'b001; cmp_wdata = 16'd9; top_sel = 1;
    cyc();
    run_peak(pk); run_peak(pk);
    chk("R3 channel A ceiling", pk, 9);

    // R4: write mid-period keeps current peak
    top_sel = 0; per_wr = 1; per_wdata = 16'd20;
    cyc();
    run_peak(pk);
    prev = count;
    for (int g = 0; g < 100 && !(count == 5 && prev == 4); g++) begin prev = count; cyc(); end
    per_wr = 1; per_wdata = 16'd8;
    cyc();
    run_peak(pk);
    run_peak(pk2);
    chk("R4 peak of running period", pk, 20);
    chk("R4 peak after bottom load", pk2, 8);

    // R9 / R8: compare above ceiling, and disabled pin
    cmp_mode = {2'd0, 2'd2, 2'd2};
    cmp_wr = 3'b010; cmp_wdata = 16'hFFFF; cyc();
    cmp_wr = 3'b100; cmp_wdata = 16'd2; cyc();
    run_peak(pk); run_peak(pk);
    clr_cmp = '1; cyc();
    held = pwm[1];
    for (int k = 0; k < 60; k++) begin
      cyc();
      chk("R9 no match flag", flag_cmp[1], 0);
      chk("R9 pin static", pwm[1], held);
      chk("R8 pin low in mode 0", pwm[2], 0);
    end
    chk("R8 flag still sets in mode 0", flag_cmp[2], 1);

    // R10: set wins over clear, then clear alone
    for (int g = 0; g < 100 && count != 0; g++) cyc();
    clr_bot = 1; tick = 1; cyc();
    chk("R10 set beats clear", flag_bot, 1);
    tick = 0; clr_bot = 1; cyc();
    chk("R10 write-one clear", flag_bot, 0);

    // constrained random section
    for (int n = 0; n < 4000; n++) begin
      tick = ($urandom % 4) != 0;
      per_wr = ($urandom % 40) == 0;
      per_wdata = W'(3 + $urandom % 38);
      for (int i = 0; i < N; i++) cmp_wr[i] = ($urandom % 30) == 0;
      cmp_wdata = W'($urandom % 45);
      if ($urandom % 200 == 0) cmp_mode = 6'($urandom);
      if ($urandom % 500 == 0) top_sel = ~top_sel;
      clr_bot = ($urandom % 8) == 0;
      clr_top = ($urandom % 8) == 0;
      for (int i = 0; i < N; i++) clr_cmp[i] = ($urandom % 8) == 0;
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule